// File: doc/BRIEF.md
# Masked Data Address Watchpoint Unit

This block watches every data access the core issues and compares its address against a set of watchpoint comparators (four by default). Each comparator holds a compare address, an ignore-width field and a function word. The ignore width clears a programmable number of low address bits before the compare, so one comparator can cover an aligned window from one byte up to 32 KiB. The function code picks whether reads, writes or both are watched. A valid access that any enabled comparator accepts raises a one-cycle debug event request on the following cycle. It also sets that comparator's sticky matched flag, which stays set until software reads the comparator's function register.

Software reaches the comparators through a simple word-indexed configuration port. A write takes effect at the clock edge. Read data is combinational from the index. A read of a function register has a side effect: it clears the sticky flag. Several function bits concern data-value matching, comparator linking, cycle matching and trace emission. These bits are kept in storage and read back, but they have no effect on matching.

Top module: `dwatch_unit`

## Requirements
- R1: Index 0 is the control word. It reads the comparator count in bits [31:28] (4 by default) and zero in every other bit. Writes to it are ignored.
- R2: Comparator i lives at index 4*(i+1). The compare address is at +0 and reads back all 32 bits written. The ignore width is at +1; only bits [3:0] are kept, and the upper bits read back as 0. The function word is at +2. Offset +3 reads as 0.
- R3: Of the function word, bits [3:0], 5, 7, 8, [11:10] and [19:12] are stored and read back. Bit 9 (linked-address support) always reads 0. Bit 24 reads the matched flag. All other bits read 0, so writing all-ones reads back 0x000FFDAF while the flag is clear.
- R4: A comparator accepts an address A when (A & (all-ones << W)) == C, where W is its ignore width and C its compare address. If C has any bit set below bit W, the comparator never matches.
- R5: Function code [3:0] = 0101 watches reads (acc_write=0). 0110 watches writes. 0111 watches both. Every other code, 0000 included, never fires.
- R6: dbg_req is high in exactly the cycle after a valid access that at least one comparator accepts, and low otherwise. Two comparators hitting together give a single request.
- R7: A comparator hit sets that comparator's matched flag from the next cycle on. The flag is visible on hit_flags[i] and in function bit 24, and it stays set until a function-register read clears it.
- R8: A read of comparator i's function register returns the flag as it stands and clears it for the next cycle. If the same comparator hits in that cycle, the flag stays set.
- R9: Reset clears every compare address, ignore width, function word and matched flag, and clears dbg_req. After reset no comparator can fire.
- R10: When acc_valid is low, no comparator fires, whatever the address.
- R11: The data-size field [11:10] and the other store-only function bits have no effect on matching. For example, size = 01 with W = 2 still accepts every address in the 4-byte window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | 32 | Data access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| cfg_sel | input | 1 | Configuration access strobe |
| cfg_wr | input | 1 | 1 = configuration write, 0 = read |
| cfg_idx | input | REG_AW (5) | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational from cfg_idx) |
| dbg_req | output | 1 | Debug event request, one cycle after a hit |
| hit_flags | output | NUM_CMP (4) | Sticky per-comparator matched flags |

## Verification
The bench builds the unit with its default of four comparators, which makes the index width five and places the last function word at index 18. That brings every comparator slot and the top of the index space within reach. With this setting the bench can give each comparator a distinct function code, so read-only, write-only, both-ways and an unused code are exercised side by side. It also covers ignore widths from 0 up to the widest value of 15, a compare address with bits below the ignore width, a flag read that coincides with a hit, and a reset in the middle of operation.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int MASK_W   = 4;
  localparam int CNT_W    = 4;
  localparam int FLAG_BIT = 24;

  // function bits that are kept in storage; bit 9 and bit 24 excluded
  localparam logic [DATA_W-1:0] FN_KEEP = 32'h000F_FDAF;

  typedef enum logic [3:0] {
    FN_OFF = 4'b0000,
    FN_RD  = 4'b0101,
    FN_WR  = 4'b0110,
    FN_RW  = 4'b0111
  } fn_code_e;

  // address compare after clearing the ignored low bits
  function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] c,
                                    input logic [MASK_W-1:0] ign);
    return (a & ({ADDR_W{1'b1}} << ign)) == c;
  endfunction

  // access kind accepted by a function code
  function automatic logic kind_ok(input logic [3:0] fn, input logic is_wr);
    case (fn)
      FN_RD:   return !is_wr;
      FN_WR:   return is_wr;
      FN_RW:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dwatch_cmp.sv
module dwatch_cmp
  import dwatch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_comp,
  input  logic              ld_mask,
  input  logic              ld_fn,
  input  logic              rd_fn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic [ADDR_W-1:0] comp_q,
  output logic [MASK_W-1:0] mask_q,
  output logic [DATA_W-1:0] fn_q,
  output logic              hit,
  output logic              matched
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q <= '0;
      mask_q <= '0;
      fn_q   <= '0;
    end else begin
      if (ld_comp) comp_q <= wdata;
      if (ld_mask) mask_q <= wdata[MASK_W-1:0];
      if (ld_fn)   fn_q   <= wdata & FN_KEEP;
    end
  end

  assign hit = acc_valid && kind_ok(fn_q[3:0], acc_write)
               && addr_hit(acc_addr, comp_q, mask_q);

  // a hit wins over the read side-effect clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     matched <= 1'b0;
    else if (hit)   matched <= 1'b1;
    else if (rd_fn) matched <= 1'b0;
  end

endmodule

// File: rtl/dwatch_evt.sv
module dwatch_evt #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_vec,
  output logic         dbg_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_req <= 1'b0;
    else        dbg_req <= |hit_vec;
  end

endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
#(
  parameter  int NUM_CMP = 4,
  localparam int REG_AW  = $clog2(4 * (NUM_CMP + 1))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_write,
  input  logic               cfg_sel,
  input  logic               cfg_wr,
  input  logic [REG_AW-1:0]  cfg_idx,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic               dbg_req,
  output logic [NUM_CMP-1:0] hit_flags
);

  localparam logic [CNT_W-1:0]  CNT_FIELD = CNT_W'(NUM_CMP);
  localparam logic [DATA_W-1:0] CTRL_WORD = {CNT_FIELD, {(DATA_W-CNT_W){1'b0}}};

  logic              cfg_wr_en;
  logic              cfg_rd_en;
  logic [NUM_CMP-1:0] hit_vec;
  logic [NUM_CMP-1:0] fn_rd;
  logic [ADDR_W-1:0] comp_arr [NUM_CMP];
  logic [MASK_W-1:0] mask_arr [NUM_CMP];
  logic [DATA_W-1:0] fn_arr   [NUM_CMP];

  assign cfg_wr_en = cfg_sel && cfg_wr;
  assign cfg_rd_en = cfg_sel && !cfg_wr;

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    localparam int BASE = 4 * (gi + 1);
    logic ld_c, ld_m, ld_f;
    assign ld_c      = cfg_wr_en && (cfg_idx == REG_AW'(BASE));
    assign ld_m      = cfg_wr_en && (cfg_idx == REG_AW'(BASE + 1));
    assign ld_f      = cfg_wr_en && (cfg_idx == REG_AW'(BASE + 2));
    assign fn_rd[gi] = cfg_rd_en && (cfg_idx == REG_AW'(BASE + 2));

    dwatch_cmp u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_comp   (ld_c),
      .ld_mask   (ld_m),
      .ld_fn     (ld_f),
      .rd_fn     (fn_rd[gi]),
      .wdata     (cfg_wdata),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_write (acc_write),
      .comp_q    (comp_arr[gi]),
      .mask_q    (mask_arr[gi]),
      .fn_q      (fn_arr[gi]),
      .hit       (hit_vec[gi]),
      .matched   (hit_flags[gi])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_idx == '0) cfg_rdata = CTRL_WORD;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (cfg_idx == REG_AW'(4 * (i + 1)))
        cfg_rdata = comp_arr[i];
      if (cfg_idx == REG_AW'(4 * (i + 1) + 1))
        cfg_rdata = {{(DATA_W-MASK_W){1'b0}}, mask_arr[i]};
      if (cfg_idx == REG_AW'(4 * (i + 1) + 2))
        cfg_rdata = fn_arr[i] | (DATA_W'(hit_flags[i]) << FLAG_BIT);
    end
  end

  dwatch_evt #(.N(NUM_CMP)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vec (hit_vec),
    .dbg_req (dbg_req)
  );

endmodule

// File: rtl/dwatch_chk.sv
module dwatch_chk #(
  parameter  int NUM_CMP = 4,
  localparam int REG_AW  = $clog2(4 * (NUM_CMP + 1))
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               cfg_sel,
  input logic               cfg_wr,
  input logic [REG_AW-1:0]  cfg_idx,
  input logic [31:0]        cfg_rdata,
  input logic               dbg_req,
  input logic [NUM_CMP-1:0] hit_flags,
  input logic [NUM_CMP-1:0] hit_vec,
  input logic [NUM_CMP-1:0] fn_rd
);

  // R1
  ctrl_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel && !cfg_wr && cfg_idx == '0) |-> cfg_rdata == {4'(NUM_CMP), 28'b0});

  // R6
  req_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> dbg_req);

  // R6
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit_vec) |=> !dbg_req);

  // R10
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> hit_vec == '0);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_flag
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[i] |=> hit_flags[i]);
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_flags[i] && !fn_rd[i]) |=> hit_flags[i]);
    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_rd[i] && !hit_vec[i]) |=> !hit_flags[i]);
    // R7
    flag_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_flags[i] && !hit_vec[i]) |=> !hit_flags[i]);
  end

endmodule

bind dwatch_unit dwatch_chk #(.NUM_CMP(NUM_CMP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .cfg_sel   (cfg_sel),
  .cfg_wr    (cfg_wr),
  .cfg_idx   (cfg_idx),
  .cfg_rdata (cfg_rdata),
  .dbg_req   (dbg_req),
  .hit_flags (hit_flags),
  .hit_vec   (hit_vec),
  .fn_rd     (fn_rd)
);

// File: tb/dwatch_unit_tb.sv
module dwatch_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        cfg_sel = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dbg_req;
  logic [3:0]  hit_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwatch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dbg_req(dbg_req),
    .hit_flags(hit_flags)
  );

  // behavioural reference
  logic [31:0] m_comp [NC];
  logic [3:0]  m_ign  [NC];
  logic [31:0] m_fn   [NC];
  bit          m_flag [NC];
  bit          m_req;

  function automatic bit m_fires(int i);
    int sh;
    bit kind;
    sh = int'(m_ign[i]);
    case (m_fn[i][3:0])
      4'd5:    kind = (acc_write == 1'b0);
      4'd6:    kind = (acc_write == 1'b1);
      4'd7:    kind = 1'b1;
      default: kind = 1'b0;
    endcase
    return acc_valid && kind && (((acc_addr >> sh) << sh) == m_comp[i]);
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] idx);
    int k;
    k = int'(idx);
    if (k == 0) return 32'h4000_0000;
    for (int i = 0; i < NC; i++) begin
      if (k == 4*i + 4) return m_comp[i];
      if (k == 4*i + 5) return {28'h0, m_ign[i]};
      if (k == 4*i + 6) return m_fn[i] | (m_flag[i] ? 32'h0100_0000 : 32'h0);
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    bit h [NC];
    bit any;
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        m_comp[i] = '0; m_ign[i] = '0; m_fn[i] = '0; m_flag[i] = 0;
      end
      m_req = 0;
    end else begin
      any = 0;
      for (int i = 0; i < NC; i++) begin
        h[i] = m_fires(i);
        if (h[i]) any = 1;
      end
      for (int i = 0; i < NC; i++) begin
        if (h[i]) m_flag[i] = 1;
        else if (cfg_sel && !cfg_wr && int'(cfg_idx) == 4*i + 6) m_flag[i] = 0;
        if (cfg_sel && cfg_wr) begin
          if (int'(cfg_idx) == 4*i + 4) m_comp[i] = cfg_wdata;
          if (int'(cfg_idx) == 4*i + 5) m_ign[i]  = cfg_wdata[3:0];
          if (int'(cfg_idx) == 4*i + 6) m_fn[i]   = cfg_wdata & 32'h000F_FDAF;
        end
      end
      m_req = any;
    end
  end

  function automatic logic [3:0] m_flag_vec();
    logic [3:0] v;
    for (int i = 0; i < NC; i++) v[i] = m_flag[i];
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // one clock, then compare against the reference at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      check(dbg_req == m_req, "R6 per-cycle dbg_req", 32'(dbg_req), 32'(m_req));
      check(hit_flags == m_flag_vec(), "R7 per-cycle hit_flags",
            32'(hit_flags), 32'(m_flag_vec()));
    end
  endtask

  task automatic idle();
    acc_valid = 0; cfg_sel = 0; cfg_wr = 0;
  endtask

  task automatic cfg_write(int idx, logic [31:0] d);
    cfg_sel = 1; cfg_wr = 1; cfg_idx = 5'(idx); cfg_wdata = d;
    tick();
    idle();
  endtask

  task automatic cfg_read(int idx, logic [31:0] exp, string tag);
    cfg_sel = 1; cfg_wr = 0; cfg_idx = 5'(idx);
    #1;
    check(cfg_rdata == exp, tag, cfg_rdata, exp);
    check(cfg_rdata == m_read(5'(idx)), "R2 read vs model", cfg_rdata, m_read(5'(idx)));
    tick();
    idle();
  endtask

  task automatic access(logic [31:0] a, bit wr, bit exp_req, string tag);
    acc_valid = 1; acc_addr = a; acc_write = wr;
    tick();
    idle();
    check(dbg_req == exp_req, tag, 32'(dbg_req), 32'(exp_req));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R9 reset state
    check(dbg_req == 0, "R9 dbg_req after reset", 32'(dbg_req), 0);
    check(hit_flags == 0, "R9 flags after reset", 32'(hit_flags), 0);
    cfg_read(0, 32'h4000_0000, "R1 control count");
    cfg_read(6, 32'h0, "R9 function cleared");
    cfg_write(0, 32'hFFFF_FFFF);
    cfg_read(0, 32'h4000_0000, "R1 control write ignored");

    // comparator 0: 16-byte window at 0x1000, both kinds
    cfg_write(4, 32'h0000_1000);
    cfg_read(4, 32'h0000_1000, "R2 compare readback");
    cfg_write(5, 32'hFFFF_FFFF);
    cfg_read(5, 32'h0000_000F, "R2 mask width");
    cfg_read(7, 32'h0, "R2 spare offset reads zero");
    cfg_write(5, 32'd4);
    cfg_write(6, 32'd7);
    cfg_write(18, 32'hFFFF_FFFF);
    cfg_read(18, 32'h000F_FDAF, "R3 stored function bits");
    cfg_write(18, 32'h0);

    access(32'h0000_100C, 0, 1, "R4 inside window");
    check(hit_flags == 4'b0001, "R7 flag set", 32'(hit_flags), 32'h1);
    tick();
    check(dbg_req == 0, "R6 request lasts one cycle", 32'(dbg_req), 0);
    access(32'h0000_1010, 1, 0, "R4 outside window");

    // access-kind codes
    cfg_write(8, 32'h2000); cfg_write(9, 0); cfg_write(10, 5);
    access(32'h2000, 1, 0, "R5 read-only ignores write");
    access(32'h2000, 0, 1, "R5 read-only fires on read");
    cfg_write(12, 32'h3000); cfg_write(13, 0); cfg_write(14, 6);
    access(32'h3000, 0, 0, "R5 write-only ignores read");
    access(32'h3000, 1, 1, "R5 write-only fires on write");
    cfg_write(16, 32'h4000); cfg_write(17, 0); cfg_write(18, 4'b0100);
    access(32'h4000, 0, 0, "R5 unused code read");
    access(32'h4000, 1, 0, "R5 unused code write");
    cfg_write(18, 0);
    check(hit_flags == 4'b0111, "R7 flags sticky", 32'(hit_flags), 32'h7);

    // clear on read
    cfg_read(6, 32'h0100_0007, "R8 flag visible in read");
    check(hit_flags == 4'b0110, "R8 flag cleared by read", 32'(hit_flags), 32'h6);
    cfg_sel = 1; cfg_wr = 0; cfg_idx = 5'd6;
    acc_valid = 1; acc_addr = 32'h1000; acc_write = 0;
    tick();
    idle();
    check(hit_flags[0] == 1, "R8 hit during read keeps flag", 32'(hit_flags[0]), 1);

    // valid low
    acc_valid = 0; acc_addr = 32'h1000; acc_write = 0;
    tick();
    check(dbg_req == 0, "R10 no valid no request", 32'(dbg_req), 0);

    // store-only size field
    cfg_write(10, 32'h0000_0405); cfg_write(9, 2);
    access(32'h2003, 0, 1, "R11 size field ignored");
    cfg_read(10, 32'h0100_0405, "R3 function readback with flag");

    // compare with bits under the ignore width
    cfg_write(8, 32'h2001);
    access(32'h2001, 0, 0, "R4 low compare bits never match");
    access(32'h2000, 0, 0, "R4 low compare bits never match aligned");

    // widest window
    cfg_write(16, 32'h8000); cfg_write(17, 15); cfg_write(18, 7);
    access(32'h0000_FFFF, 1, 1, "R4 wide window top");
    access(32'h0001_0000, 0, 0, "R4 wide window above");
    access(32'h0000_7FFF, 0, 0, "R4 wide window below");

    // two comparators at once
    cfg_write(12, 32'h1000); cfg_write(13, 0); cfg_write(14, 6);
    cfg_read(14, 32'h0100_0006, "R8 clear flag 2");
    access(32'h1000, 1, 1, "R6 two hits single request");
    check(hit_flags[2] == 1 && hit_flags[0] == 1, "R7 both flags",
          32'(hit_flags), 32'h5);

    // reset mid-run
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    check(hit_flags == 0, "R9 flags after second reset", 32'(hit_flags), 0);
    cfg_read(18, 32'h0, "R9 function after second reset");
    access(32'h8000, 1, 0, "R9 disabled after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule